// File: doc/BRIEF.md
# Impedance Calibration Code Controller

This block holds the two 7-bit drive-strength codes, pull-up (P) and pull-down (N), that set the output impedance of a pad calibration macro. Off-chip comparators report, for each code, whether it should move up, move down, or already matches the reference resistor. Those reports reach the block as plain digital inputs. Each request passes through a per-channel filter, which applies a one-step change only after the same direction has been requested on a programmable number of consecutive cycles.

Software programs one control register. It selects bypass or dynamic mode, freezes updates with a lock bit, sets the filter depth, and restarts the loop by pulsing an active-low clear bit. A sticky ready flag reports when training has converged. In bypass the codes presented to the pads are the fixed defaults. In dynamic mode they are the trained values.

Top module: `imp_cal_ctrl`

## Requirements
- R1: After reset all control bits and ready are 0, both code outputs equal the default value 1, and the read-only default fields read 1.
- R2: The control word places enable at bit 6, ready at bit 5 (read-only), lock at bit 4, filter at bits 3:1 and clear-bar at bit 0. The P default reads at bits 22:16 and the N default at bits 14:8. Every other bit reads 0.
- R3: While enable is 0, both code outputs equal the default, whatever the requests are, and the internal codes are reloaded with the default.
- R4: With filter 0, every cycle that carries a valid request moves its code by exactly one step in the requested direction.
- R5: With filter value f, a code steps only on the (f+1)-th consecutive cycle with the same request direction, and the run count then restarts. The count also restarts on a cycle with no request, on a conflicting request (both up and down asserted), on a match, or on a change of direction.
- R6: Codes saturate at 0 and 127 and never wrap.
- R7: While lock is 1, codes hold and the filter counts are cleared.
- R8: A 0-to-1 transition of clear-bar, detected one cycle after it is written, returns both codes to the default, clears both filter counts and clears ready.
- R9: Ready is set when, in dynamic unlocked mode, a channel reports a match or a qualified step is blocked at a limit. It stays set until a clear event or until enable is 0.
- R10: The P and N channels filter and step independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 32 | Control register write data |
| regRdData | output | 32 | Control register read data |
| pInc | input | 1 | P comparator: raise P code |
| pDec | input | 1 | P comparator: lower P code |
| pMatch | input | 1 | P comparator: P code matches |
| nInc | input | 1 | N comparator: raise N code |
| nDec | input | 1 | N comparator: lower N code |
| nMatch | input | 1 | N comparator: N code matches |
| pCode | output | 7 | P drive code to the pads |
| nCode | output | 7 | N drive code to the pads |

## Verification
Directed patterns run steady one-direction streams at filter 0 and at a deeper filter, so step rate can be told apart from filter depth. Runs are broken by idle cycles, conflicting requests, matches and reversals, each of which must restart the count. Long streams into both limits separate saturation from wrap-around. Opposite requests on P and N in the same cycles expose cross-talk between channels. Seeded random request mixes, with random rewrites of the control word (including lock, bypass and clear pulses), are compared cycle by cycle against a bench model built from the requirements.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;
  localparam int CODE_W   = 7;
  localparam int FILT_W   = 3;
  localparam int DEF_CODE = 1;

  localparam int BIT_CLRZ  = 0;
  localparam int FILT_LSB  = 1;
  localparam int BIT_LOCK  = 4;
  localparam int BIT_RDY   = 5;
  localparam int BIT_EN    = 6;
  localparam int NDEF_LSB  = 8;
  localparam int PDEF_LSB  = 16;

  typedef struct packed {
    logic run;    // dynamic mode and not locked
    logic clear;  // reload defaults, drop counts
  } calStrobe_t;
endpackage

// File: rtl/icc_ctrl.sv
module icc_ctrl
  import imp_cal_pkg::*;
#(
  parameter int CW     = CODE_W,
  parameter int FW     = FILT_W,
  parameter int DEFVAL = DEF_CODE,
  parameter int NCH    = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [31:0]   regWrData,
  input  logic [NCH-1:0] stopEvt,
  output calStrobe_t    strobe,
  output logic [FW-1:0] filtSel,
  output logic          enable,
  output logic [31:0]   regRdData
);
  logic lockReg, clrzReg, clrzPrev, readyReg, clearEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      lockReg  <= 1'b0;
      filtSel  <= '0;
      clrzReg  <= 1'b0;
      clrzPrev <= 1'b0;
    end else begin
      clrzPrev <= clrzReg;
      if (regWrEn) begin
        enable  <= regWrData[BIT_EN];
        lockReg <= regWrData[BIT_LOCK];
        filtSel <= regWrData[FILT_LSB +: FW];
        clrzReg <= regWrData[BIT_CLRZ];
      end
    end
  end

  assign clearEdge    = clrzReg & ~clrzPrev;
  assign strobe.run   = enable & ~lockReg;
  assign strobe.clear = clearEdge | ~enable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             readyReg <= 1'b0;
    else if (strobe.clear) readyReg <= 1'b0;
    else if (|stopEvt)     readyReg <= 1'b1;
  end

  always_comb begin
    regRdData                       = '0;
    regRdData[PDEF_LSB +: CW]       = CW'(DEFVAL);
    regRdData[NDEF_LSB +: CW]       = CW'(DEFVAL);
    regRdData[BIT_EN]               = enable;
    regRdData[BIT_RDY]              = readyReg;
    regRdData[BIT_LOCK]             = lockReg;
    regRdData[FILT_LSB +: FW]       = filtSel;
    regRdData[BIT_CLRZ]             = clrzReg;
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !readyReg); // R9
  AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    clearEdge |=> !clearEdge); // R8
endmodule

// File: rtl/icc_chan.sv
module icc_chan
  import imp_cal_pkg::*;
#(
  parameter int CW     = CODE_W,
  parameter int FW     = FILT_W,
  parameter int DEFVAL = DEF_CODE
) (
  input  logic          clk,
  input  logic          rstN,
  input  calStrobe_t    strobe,
  input  logic [FW-1:0] filtSel,
  input  logic          incReq,
  input  logic          decReq,
  input  logic          matchIn,
  output logic [CW-1:0] code,
  output logic          stopEvt
);
  localparam int CNTW = FW + 1;
  localparam logic [CW-1:0] CODE_MAX = '1;
  localparam logic [CW-1:0] CODE_DEF = CW'(DEFVAL);

  logic [CNTW-1:0] runCnt, nextCnt, thresh;
  logic            lastUp, validReq, fire, atLimit;

  always_comb begin
    thresh   = CNTW'(filtSel) + 1'b1;
    validReq = (incReq ^ decReq) & ~matchIn;
    nextCnt  = (runCnt != '0 && lastUp == incReq) ? runCnt + 1'b1 : CNTW'(1);
    fire     = strobe.run & validReq & (nextCnt >= thresh);
    atLimit  = incReq ? (code == CODE_MAX) : (code == '0);
    stopEvt  = strobe.run & ~strobe.clear &
               (matchIn | (fire & atLimit));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code   <= CODE_DEF;
      runCnt <= '0;
      lastUp <= 1'b0;
    end else if (strobe.clear) begin
      code   <= CODE_DEF;
      runCnt <= '0;
    end else if (!strobe.run || !validReq) begin
      runCnt <= '0;
    end else begin
      lastUp <= incReq;
      if (fire) begin
        runCnt <= '0;
        if (!atLimit) code <= incReq ? code + 1'b1 : code - 1'b1;
      end else begin
        runCnt <= nextCnt;
      end
    end
  end

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clear |=> (code == $past(code) || code == $past(code) + 1'b1 ||
                       code == $past(code) - 1'b1)); // R4
  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (code == CODE_MAX && !strobe.clear) |=> code != '0); // R6
  AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (!rstN)
    (code == '0 && !strobe.clear) |=> code != CODE_MAX); // R6
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.clear) |=> $stable(code)); // R7
endmodule

// File: rtl/imp_cal_ctrl.sv
module imp_cal_ctrl
  import imp_cal_pkg::*;
#(
  parameter int CW     = CODE_W,
  parameter int FW     = FILT_W,
  parameter int DEFVAL = DEF_CODE
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [31:0]   regWrData,
  output logic [31:0]   regRdData,
  input  logic          pInc,
  input  logic          pDec,
  input  logic          pMatch,
  input  logic          nInc,
  input  logic          nDec,
  input  logic          nMatch,
  output logic [CW-1:0] pCode,
  output logic [CW-1:0] nCode
);
  localparam int NCH = 2;

  calStrobe_t     strobe;
  logic [FW-1:0]  filtSel;
  logic           enable;
  logic [NCH-1:0] stopEvt, incV, decV, matchV;
  logic [CW-1:0]  chCode [NCH];

  assign incV   = {nInc, pInc};
  assign decV   = {nDec, pDec};
  assign matchV = {nMatch, pMatch};

  icc_ctrl #(.CW(CW), .FW(FW), .DEFVAL(DEFVAL), .NCH(NCH)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .stopEvt(stopEvt), .strobe(strobe), .filtSel(filtSel),
    .enable(enable), .regRdData(regRdData)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    icc_chan #(.CW(CW), .FW(FW), .DEFVAL(DEFVAL)) i_chan (
      .clk(clk), .rstN(rstN), .strobe(strobe), .filtSel(filtSel),
      .incReq(incV[g]), .decReq(decV[g]), .matchIn(matchV[g]),
      .code(chCode[g]), .stopEvt(stopEvt[g])
    );
  end

  assign pCode = enable ? chCode[0] : CW'(DEFVAL);
  assign nCode = enable ? chCode[1] : CW'(DEFVAL);

  AST_BYPASS_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (pCode == CW'(DEFVAL) && nCode == CW'(DEFVAL))); // R3
endmodule

// File: tb/test_imp_cal_ctrl.sv
module test_imp_cal_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEF = 1;

  logic clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0;
  logic [31:0] regWrData = '0, regRdData;
  logic [5:0] req = '0; // {nMatch,nDec,nInc,pMatch,pDec,pInc}
  logic [6:0] pCode, nCode;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  imp_cal_ctrl i_imp_cal_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .pInc(req[0]), .pDec(req[1]), .pMatch(req[2]),
    .nInc(req[3]), .nDec(req[4]), .nMatch(req[5]), .pCode(pCode), .nCode(nCode)
  );

  // bench model of the requirements
  logic mEn, mLock, mClrz, mClrzPrev, mReady;
  logic [2:0] mFilt;
  int mCode [2], mCnt [2];
  logic mUp [2];

  function automatic logic [31:0] expRd();
    return {9'b0, 7'(DEF), 1'b0, 7'(DEF), 1'b0, mEn, mReady, mLock, mFilt, mClrz};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mEn = 0; mLock = 0; mClrz = 0; mClrzPrev = 0; mReady = 0; mFilt = 0;
      for (int c = 0; c < 2; c++) begin mCode[c] = DEF; mCnt[c] = 0; mUp[c] = 0; end
    end else begin
      logic clr, run, stop;
      clr = (mClrz & ~mClrzPrev) | ~mEn;
      run = mEn & ~mLock;
      stop = 0;
      for (int c = 0; c < 2; c++) begin
        logic inc, dec, mat;
        int n;
        inc = req[3*c]; dec = req[3*c+1]; mat = req[3*c+2];
        if (clr) begin mCode[c] = DEF; mCnt[c] = 0; end
        else if (!run) mCnt[c] = 0;
        else if (!(inc ^ dec) || mat) begin mCnt[c] = 0; if (mat) stop = 1; end
        else begin
          n = (mCnt[c] != 0 && mUp[c] == inc) ? mCnt[c] + 1 : 1;
          mUp[c] = inc;
          if (n >= int'(mFilt) + 1) begin
            mCnt[c] = 0;
            if (inc) begin if (mCode[c] == 127) stop = 1; else mCode[c]++; end
            else begin if (mCode[c] == 0) stop = 1; else mCode[c]--; end
          end else mCnt[c] = n;
        end
      end
      if (clr) mReady = 0; else if (stop) mReady = 1;
      mClrzPrev = mClrz;
      if (regWrEn) begin
        mEn = regWrData[6]; mLock = regWrData[4]; mFilt = regWrData[3:1]; mClrz = regWrData[0];
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cmpAll(string tag);
    chk(tag, 32'(pCode), 32'(mEn ? mCode[0] : DEF), "pCode");
    chk(tag, 32'(nCode), 32'(mEn ? mCode[1] : DEF), "nCode");
    chk(tag, regRdData, expRd(), "regRdData");
  endtask

  task automatic step(string tag, logic [5:0] r, int n = 1);
    for (int i = 0; i < n; i++) begin
      req = r;
      @(negedge clk);
      cmpAll(tag);
    end
  endtask

  task automatic wr(string tag, logic [31:0] d);
    req = '0; regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    cmpAll(tag);
  endtask

  function automatic logic [31:0] ctl(bit en, bit lk, int f, bit cz);
    return 32'((en << 6) | (lk << 4) | ((f & 7) << 1) | cz);
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", regRdData, 32'h0001_0100, "reset readback");
    chk("R1", 32'(pCode), 1, "reset pCode");
    chk("R1", 32'(nCode), 1, "reset nCode");
    // R3 bypass ignores requests
    step("R3", 6'b010001, 5);
    chk("R3", 32'(pCode), 1, "bypass pCode");
    // R2 layout readback with filter 5, lock
    wr("R2", 32'hFFFF_0000 | ctl(1, 1, 5, 1));
    chk("R2", regRdData, 32'h0001_015B, "layout");
    // R8 clear then run filter 0
    wr("R8", ctl(1, 0, 0, 0));
    wr("R8", ctl(1, 0, 0, 1));
    step("R8", 6'b0, 1);
    // R4 each request steps
    step("R4", 6'b000001, 3);
    chk("R4", 32'(pCode), 4, "three steps up");
    // R10 opposite directions on the two channels
    step("R10", 6'b001010, 2);
    chk("R10", 32'(pCode), 2, "P down");
    chk("R10", 32'(nCode), 3, "N up");
    // R5 filter 2: three in a row
    wr("R5", ctl(1, 0, 2, 1));
    step("R5", 6'b000001, 2);
    step("R5", 6'b000000, 1);
    step("R5", 6'b000001, 2);
    step("R5", 6'b000010, 1);
    step("R5", 6'b000011, 1);
    chk("R5", 32'(pCode), 2, "broken runs do not step");
    step("R5", 6'b000001, 3);
    chk("R5", 32'(pCode), 3, "third request steps");
    // R6 saturation high and low
    wr("R6", ctl(1, 0, 0, 1));
    step("R6", 6'b000001, 140);
    chk("R6", 32'(pCode), 127, "top saturate");
    chk("R9", 32'(regRdData[5]), 1, "ready on blocked step");
    step("R6", 6'b000010, 140);
    chk("R6", 32'(pCode), 0, "bottom saturate");
    // R7 lock freezes
    wr("R7", ctl(1, 1, 0, 1));
    step("R7", 6'b001001, 6);
    chk("R7", 32'(pCode), 0, "locked P");
    // R8 clear pulse restores defaults and drops ready
    wr("R8", ctl(1, 0, 0, 0));
    wr("R8", ctl(1, 0, 0, 1));
    step("R8", 6'b0, 1);
    chk("R8", 32'(pCode), 1, "cleared P");
    chk("R8", 32'(regRdData[5]), 0, "ready cleared");
    // R9 match sets ready; disable drops it
    step("R9", 6'b100000, 1);
    chk("R9", 32'(regRdData[5]), 1, "ready on match");
    wr("R9", ctl(0, 0, 0, 1));
    step("R9", 6'b0, 1);
    chk("R9", 32'(regRdData[5]), 0, "ready dropped by bypass");
    // random mix against the model
    wr("R5", ctl(1, 0, 1, 1));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 60) == 0)
        wr("R5", ctl($urandom_range(0, 9) != 0, $urandom_range(0, 5) == 0,
                     $urandom_range(0, 7), $urandom_range(0, 3) != 0));
      else
        step("R5", 6'($urandom_range(0, 63) & ($urandom_range(0, 3) == 0 ? 6'h3F : 6'h1B)));
    end
    summary();
  end
endmodule